// File: doc/BRIEF.md
# Sliced Last-Level Cache Tag Lookup

This block is the tag side of a last-level cache divided into slices. Each request carries a physical address. A parity hash over address bits 17 to 31 chooses the slice. The bits just above the 64-byte line offset choose the set. The block then looks up that set in a 12-way tag store and reports hit or miss, together with the way that now holds the line. Replacement within each set is true LRU. No data is stored, so the block suits placement studies, eviction-set analysis and conflict modelling.

A parameter picks a 2-slice or a 4-slice organisation. A second parameter shrinks the implemented set index below the full 11 bits so the store stays small. Shrinking the index does not move any bit that the hash reads, and it does not move the start of the index field. A flush input empties every set in one cycle.

Top module: `sliced_llc_tag`

## Requirements
- R1: The set index is `reqAddr[6 +: SET_BITS]`, the low end of the 11-bit field at bits 6..16. Bits 0..5 are the byte offset within the 64-byte line and do not affect placement or the tag. An access that differs only in those bits hits the same line.
- R2: With `NUM_SLICES`=4, bit 0 of the slice is the parity of address bits {31,30,29,27,25,23,21,19,18}. Bit 1 of the slice is the parity of address bits {31,29,28,26,24,23,22,21,20,19,17}.
- R3: With `NUM_SLICES`=2, the 1-bit slice is the parity of address bits {30,28,27,26,25,24,22,20,18,17}. This equals the XOR of the two 4-slice bits.
- R4: Address bits 32 and above never change the slice or the set. They do take part in the tag compare.
- R5: A request accepted at a clock edge produces `rspValid`=1 in the following cycle for exactly one cycle. In that cycle `rspHit`, `rspSlice`, `rspSet` and `rspWay` describe that request. Requests may arrive on consecutive cycles, and each one sees the updates made by the request before it.
- R6: On a miss, the new tag goes to the lowest-numbered invalid way of the set. If no way is invalid, it replaces the least recently used way. The filled way becomes most recently used, and `rspWay` names it.
- R7: On a hit, `rspWay` names the way that holds the tag. The only state that changes is the recency order of the set.
- R8: Twelve distinct lines that share a slice and set all hit once loaded. Thirteen such lines, accessed in a repeating cycle, miss on every access.
- R9: `flush`=1 invalidates every way of every set at the next edge. A request presented in the same cycle as `flush` is dropped and gives no response. The next access to any line misses and fills way 0.
- R10: After reset `rspValid` is 0 and every way is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Lookup request strobe |
| reqAddr | input | PADDR_W | Physical address of the request |
| flush | input | 1 | Invalidate all ways; takes priority over a request |
| rspValid | output | 1 | Result valid, one cycle after the request |
| rspHit | output | 1 | 1 = hit, 0 = miss (line filled) |
| rspSlice | output | SLICE_W | Slice chosen by the hash (1 bit in 2-slice mode, 2 bits in 4-slice mode) |
| rspSet | output | SET_BITS | Set index within the slice |
| rspWay | output | WAY_W | Way that holds the line after the access |

## Verification
The bench builds two copies of the block from the same stimulus. One uses the default 4-slice organisation and the other uses 2 slices. Both keep `PADDR_W`=36 and `SET_BITS`=4, so a single pass over single-bit and mixed addresses checks both hash variants against parities the bench computes itself. With 36 address bits, sixteen lines can differ only in bits 32..35. Such lines are certain to share a slice and set, which lets the bench hold a set full, overfill it by one, and trace the exact LRU victim order without searching for colliding addresses.

// File: rtl/llc_pkg.sv
package llc_pkg;

  // Parity masks over physical address bits 31..0 for the slice hash
  localparam logic [31:0] SLICE_MASK_LO = 32'hEAAC_0000; // 4-slice, bit 0
  localparam logic [31:0] SLICE_MASK_HI = 32'hB5FA_0000; // 4-slice, bit 1
  localparam logic [31:0] SLICE_MASK_2  = 32'h5F56_0000; // 2-slice

  localparam int LINE_BITS = 6;  // byte offset within a 64-byte line
  localparam int HASH_LSB  = 17;
  localparam int HASH_MSB  = 31;
  localparam int HASH_W    = HASH_MSB - HASH_LSB + 1;

  // Strobes from control to datapath
  typedef struct packed {
    logic lookupEn;
    logic flushEn;
  } llcStrobe_t;

endpackage

// File: rtl/llc_slice_hash.sv
module llc_slice_hash #(
  parameter int NUM_SLICES = 4,
  localparam int SLICE_W = (NUM_SLICES == 4) ? 2 : 1
) (
  input  logic [llc_pkg::HASH_W-1:0] hashBits,
  output logic [SLICE_W-1:0]         slice
);
  import llc_pkg::*;

  logic [31:0] fullBits;
  assign fullBits = {hashBits, {HASH_LSB{1'b0}}};

  generate
    if (NUM_SLICES == 4) begin : g_four
      assign slice = {^(fullBits & SLICE_MASK_HI), ^(fullBits & SLICE_MASK_LO)};
    end else begin : g_two
      assign slice = ^(fullBits & SLICE_MASK_2);
    end
  endgenerate

endmodule

// File: rtl/llc_ctrl.sv
module llc_ctrl (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                flush,
  output llc_pkg::llcStrobe_t strobe,
  output logic                rspValid
);
  import llc_pkg::*;

  // A flush wins; a request in the same cycle is dropped
  always_comb begin
    strobe.flushEn  = flush;
    strobe.lookupEn = reqValid & ~flush;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= strobe.lookupEn;
  end

endmodule

// File: rtl/llc_tag_datapath.sv
module llc_tag_datapath #(
  parameter int WAYS     = 12,
  parameter int SET_BITS = 4,
  parameter int SLICE_W  = 2,
  parameter int TAG_W    = 26,
  localparam int WAY_W   = $clog2(WAYS),
  localparam int AGE_W   = $clog2(WAYS),
  localparam int ROW_W   = SLICE_W + SET_BITS,
  localparam int ROWS    = 1 << ROW_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  llc_pkg::llcStrobe_t strobe,
  input  logic [SLICE_W-1:0]  slice,
  input  logic [SET_BITS-1:0] setIdx,
  input  logic [TAG_W-1:0]    tag,
  output logic                rspHit,
  output logic [SLICE_W-1:0]  rspSlice,
  output logic [SET_BITS-1:0] rspSet,
  output logic [WAY_W-1:0]    rspWay
);
  import llc_pkg::*;

  logic [TAG_W-1:0] tagMem   [ROWS][WAYS];
  logic             validMem [ROWS][WAYS];
  logic [AGE_W-1:0] ageMem   [ROWS][WAYS]; // 0 = most recent

  logic [ROW_W-1:0] rowIdx;
  assign rowIdx = {slice, setIdx};

  logic [WAYS-1:0] hitVec;
  logic [WAYS-1:0] freeVec;

  generate
    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hitVec[w]  = validMem[rowIdx][w] && (tagMem[rowIdx][w] == tag);
      assign freeVec[w] = !validMem[rowIdx][w];
    end
  endgenerate

  logic             hitAny;
  logic [WAY_W-1:0] hitWay;
  logic             freeAny;
  logic [WAY_W-1:0] freeWay;
  logic [WAY_W-1:0] lruWay;
  logic [WAY_W-1:0] selWay;
  logic [AGE_W-1:0] selAge;

  always_comb begin
    hitAny  = 1'b0;
    hitWay  = '0;
    freeAny = 1'b0;
    freeWay = '0;
    lruWay  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (!hitAny && hitVec[w]) begin
        hitAny = 1'b1;
        hitWay = WAY_W'(w);
      end
      if (!freeAny && freeVec[w]) begin
        freeAny = 1'b1;
        freeWay = WAY_W'(w);
      end
      if (ageMem[rowIdx][w] == AGE_W'(WAYS - 1)) lruWay = WAY_W'(w);
    end
    if (hitAny)       selWay = hitWay;
    else if (freeAny) selWay = freeWay;
    else              selWay = lruWay;
    selAge = ageMem[rowIdx][selWay];
  end

  // Tag, valid and recency state
  always_ff @(posedge clk) begin
    if (!rstN || strobe.flushEn) begin
      for (int r = 0; r < ROWS; r++) begin
        for (int w = 0; w < WAYS; w++) begin
          validMem[r][w] <= 1'b0;
          ageMem[r][w]   <= AGE_W'(w);
        end
      end
    end else if (strobe.lookupEn) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WAY_W'(w) == selWay) begin
          ageMem[rowIdx][w]   <= '0;
          validMem[rowIdx][w] <= 1'b1;
          if (!hitAny) tagMem[rowIdx][w] <= tag;
        end else if (ageMem[rowIdx][w] < selAge) begin
          ageMem[rowIdx][w] <= ageMem[rowIdx][w] + AGE_W'(1);
        end
      end
    end
  end

  // Registered result
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspHit   <= 1'b0;
      rspSlice <= '0;
      rspSet   <= '0;
      rspWay   <= '0;
    end else if (strobe.lookupEn) begin
      rspHit   <= hitAny;
      rspSlice <= slice;
      rspSet   <= setIdx;
      rspWay   <= selWay;
    end
  end

endmodule

// File: rtl/sliced_llc_tag.sv
module sliced_llc_tag #(
  parameter int PADDR_W    = 36,
  parameter int NUM_SLICES = 4,
  parameter int SET_BITS   = 4,
  parameter int WAYS       = 12,
  localparam int SLICE_W   = (NUM_SLICES == 4) ? 2 : 1,
  localparam int WAY_W     = $clog2(WAYS),
  localparam int IDX_LSB   = llc_pkg::LINE_BITS,
  localparam int TAG_LSB   = IDX_LSB + SET_BITS,
  localparam int TAG_W     = PADDR_W - TAG_LSB
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic [PADDR_W-1:0]  reqAddr,
  input  logic                flush,
  output logic                rspValid,
  output logic                rspHit,
  output logic [SLICE_W-1:0]  rspSlice,
  output logic [SET_BITS-1:0] rspSet,
  output logic [WAY_W-1:0]    rspWay
);
  import llc_pkg::*;

  llcStrobe_t          strobe;
  logic [SLICE_W-1:0]  slice;

  llc_slice_hash #(.NUM_SLICES(NUM_SLICES)) u_hash (
    .hashBits (reqAddr[HASH_MSB:HASH_LSB]),
    .slice    (slice)
  );

  llc_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .flush    (flush),
    .strobe   (strobe),
    .rspValid (rspValid)
  );

  llc_tag_datapath #(
    .WAYS     (WAYS),
    .SET_BITS (SET_BITS),
    .SLICE_W  (SLICE_W),
    .TAG_W    (TAG_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .slice    (slice),
    .setIdx   (reqAddr[IDX_LSB +: SET_BITS]),
    .tag      (reqAddr[PADDR_W-1:TAG_LSB]),
    .rspHit   (rspHit),
    .rspSlice (rspSlice),
    .rspSet   (rspSet),
    .rspWay   (rspWay)
  );

endmodule

// File: rtl/llc_tag_checker.sv
module llc_tag_checker #(
  parameter int PADDR_W  = 36,
  parameter int SET_BITS = 4,
  parameter int WAYS     = 12,
  parameter int WAY_W    = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic [PADDR_W-1:0]  reqAddr,
  input logic                flush,
  input logic                rspValid,
  input logic                rspHit,
  input logic [SET_BITS-1:0] rspSet,
  input logic [WAY_W-1:0]    rspWay
);

  // R5: one response per accepted request, one cycle later
  p_resp_timing_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid == $past(reqValid && !flush))
    else $error("response timing");

  // R9: a flush cycle yields no response in the next cycle
  p_flush_drops_r9: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !rspValid)
    else $error("flush produced a response");

  // R9: the first lookup after a flush misses
  p_miss_after_flush_r9: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && $past(flush, 2)) |-> !rspHit)
    else $error("hit right after flush");

  // R6: the reported way exists
  p_way_range_r6: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspWay < WAY_W'(WAYS)))
    else $error("way out of range");

  // R1: reported set comes from the index field of the request
  p_set_field_r1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (rspSet == $past(reqAddr[6 +: SET_BITS])))
    else $error("set index mismatch");

endmodule

bind sliced_llc_tag llc_tag_checker #(
  .PADDR_W  (PADDR_W),
  .SET_BITS (SET_BITS),
  .WAYS     (WAYS),
  .WAY_W    (WAY_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqAddr  (reqAddr),
  .flush    (flush),
  .rspValid (rspValid),
  .rspHit   (rspHit),
  .rspSet   (rspSet),
  .rspWay   (rspWay)
);

// File: tb/sliced_llc_tag_tb.sv
module sliced_llc_tag_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PADDR_W  = 36;
  localparam int SET_BITS = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [PADDR_W-1:0] reqAddr = '0;
  logic flush = 1'b0;

  logic rspValid, rspHit;
  logic [1:0] rspSlice;
  logic [SET_BITS-1:0] rspSet;
  logic [3:0] rspWay;

  logic rspValid2, rspHit2;
  logic [0:0] rspSlice2;
  logic [SET_BITS-1:0] rspSet2;
  logic [3:0] rspWay2;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sliced_llc_tag #(.PADDR_W(PADDR_W), .NUM_SLICES(4), .SET_BITS(SET_BITS)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .flush(flush),
    .rspValid(rspValid), .rspHit(rspHit), .rspSlice(rspSlice), .rspSet(rspSet), .rspWay(rspWay));

  sliced_llc_tag #(.PADDR_W(PADDR_W), .NUM_SLICES(2), .SET_BITS(SET_BITS)) u_dut2 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr), .flush(flush),
    .rspValid(rspValid2), .rspHit(rspHit2), .rspSlice(rspSlice2), .rspSet(rspSet2), .rspWay(rspWay2));

  // Independent expected-value functions
  function automatic logic [1:0] expSlice4(logic [PADDR_W-1:0] a);
    logic h1, h2;
    h1 = a[18]^a[19]^a[21]^a[23]^a[25]^a[27]^a[29]^a[30]^a[31];
    h2 = a[17]^a[19]^a[20]^a[21]^a[22]^a[23]^a[24]^a[26]^a[28]^a[29]^a[31];
    return {h2, h1};
  endfunction

  function automatic logic expSlice2(logic [PADDR_W-1:0] a);
    return a[17]^a[18]^a[20]^a[22]^a[24]^a[25]^a[26]^a[27]^a[28]^a[30];
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One request; results captured just after the edge that registers them
  logic capHit, capValid, capValid2;
  logic [1:0] capSlice;
  logic capSlice2;
  logic [SET_BITS-1:0] capSet;
  logic [3:0] capWay;

  task automatic access(logic [PADDR_W-1:0] a);
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr = a;
    @(posedge clk);
    #1;
    reqValid = 1'b0;
    capValid = rspValid;
    capValid2 = rspValid2;
    capHit = rspHit;
    capSlice = rspSlice;
    capSlice2 = rspSlice2;
    capSet = rspSet;
    capWay = rspWay;
    @(negedge clk);
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  // Line i of a conflict group: differs only in bits 32..35
  function automatic logic [PADDR_W-1:0] grp(int i);
    return {4'(i), 32'h1234_5A80};
  endfunction

  task automatic testReset();
    @(negedge clk);
    check(rspValid == 1'b0, "R10 rspValid after reset", rspValid, 0);
    access(grp(0));
    check(capHit == 1'b0 && capWay == 4'd0, "R10 first access misses into way 0", {capHit, capWay}, 0);
  endtask

  task automatic testHash();
    logic [PADDR_W-1:0] list [20];
    for (int b = 17; b <= 31; b++) list[b-17] = PADDR_W'(64'(1) << b);
    list[15] = 36'h0_DEAD_BEC0;
    list[16] = 36'h0_8765_4321;
    list[17] = 36'h0_FFFF_FFFF;
    list[18] = 36'h0_0F0F_0F40;
    list[19] = 36'h0_3C5A_A5C0;
    doFlush();
    for (int i = 0; i < 20; i++) begin
      access(list[i]);
      check(capValid && capValid2, "R5 response valid after one cycle", {capValid, capValid2}, 2'b11);
      check(capSlice == expSlice4(list[i]), "R2 4-slice hash", capSlice, expSlice4(list[i]));
      check(capSlice2 == expSlice2(list[i]), "R3 2-slice hash", capSlice2, expSlice2(list[i]));
      check(capSet == list[i][6 +: SET_BITS], "R1 set index", capSet, list[i][6 +: SET_BITS]);
    end
  endtask

  task automatic testHighBits();
    logic [1:0] s0; logic s20; logic [SET_BITS-1:0] st0;
    access(36'h0_ABCD_E1C0);
    s0 = capSlice; s20 = capSlice2; st0 = capSet;
    access(36'h5_ABCD_E1C0);
    check(capSlice == s0 && capSlice2 == s20 && capSet == st0, "R4 high bits ignored for placement",
          {capSlice, capSlice2, capSet}, {s0, s20, st0});
    check(capHit == 1'b0, "R4 high bits still distinguish tags", capHit, 0);
  endtask

  task automatic testOffset();
    doFlush();
    access(36'h0_0042_0180);
    check(!capHit, "R1 cold miss", capHit, 0);
    access(36'h0_0042_01BF);
    check(capHit && capWay == 0, "R1 offset bits ignored: hit", {capHit, capWay}, {1'b1, 4'd0});
    access(36'h0_0042_0180);
    check(capHit, "R7 repeat hits", capHit, 1);
  endtask

  task automatic testFit();
    int bad;
    doFlush();
    for (int i = 0; i < 12; i++) begin
      access(grp(i));
      check(!capHit && capWay == 4'(i), "R6 fill lowest invalid way", {capHit, capWay}, {1'b0, 4'(i)});
    end
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      access(grp(i));
      if (!(capHit && capWay == 4'(i))) bad++;
    end
    check(bad == 0, "R8 twelve lines all hit in place", bad, 0);
  endtask

  task automatic testLru();
    doFlush();
    for (int i = 0; i < 12; i++) access(grp(i));
    access(grp(0));
    check(capHit && capWay == 0, "R7 hit reports way 0", {capHit, capWay}, {1'b1, 4'd0});
    access(grp(12));
    check(!capHit && capWay == 1, "R6 evict LRU way 1", {capHit, capWay}, {1'b0, 4'd1});
    access(grp(0));
    check(capHit && capWay == 0, "R7 touched line survived", {capHit, capWay}, {1'b1, 4'd0});
    access(grp(1));
    check(!capHit && capWay == 2, "R6 next victim way 2", {capHit, capWay}, {1'b0, 4'd2});
  endtask

  task automatic testThrash();
    int hits;
    doFlush();
    for (int r = 0; r < 3; r++) begin
      hits = 0;
      for (int i = 0; i < 13; i++) begin
        access(grp(i));
        if (capHit) hits++;
      end
      check(hits == 0, "R8 thirteen lines always miss", hits, 0);
    end
  endtask

  task automatic testFlush();
    doFlush();
    access(grp(3));
    access(grp(3));
    check(capHit, "R9 line present before flush", capHit, 1);
    @(negedge clk);
    flush = 1'b1;
    reqValid = 1'b1;
    reqAddr = grp(3);
    @(posedge clk);
    #1;
    check(rspValid == 1'b0, "R9 request with flush dropped", rspValid, 0);
    @(negedge clk);
    flush = 1'b0;
    reqValid = 1'b0;
    @(negedge clk);
    check(rspValid == 1'b0, "R9 no late response", rspValid, 0);
    access(grp(3));
    check(!capHit && capWay == 0, "R9 miss into way 0 after flush", {capHit, capWay}, {1'b0, 4'd0});
  endtask

  task automatic testBackToBack();
    doFlush();
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr = grp(7);
    @(posedge clk);
    #1;
    check(rspValid && !rspHit, "R5 first of pair misses", {rspValid, rspHit}, 2'b10);
    @(negedge clk);
    reqAddr = grp(7);
    @(posedge clk);
    #1;
    check(rspValid && rspHit && rspWay == 0, "R5 second of pair sees fill", {rspValid, rspHit, rspWay}, {2'b11, 4'd0});
    reqValid = 1'b0;
    @(posedge clk);
    #1;
    check(!rspValid, "R5 single-cycle response", rspValid, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testHash();
    testHighBits();
    testOffset();
    testFit();
    testLru();
    testThrash();
    testFlush();
    testBackToBack();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule